// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Bus Handshake

This block is the digital heart of an 8-bit successive-approximation analog-to-digital converter that hangs directly on a microprocessor bus. A host starts a conversion by writing to the block: the start of the write cycle (chip select and write strobe both low) clears the pending interrupt and arms the sequencer. The end of the write cycle launches the conversion. The sequencer then resolves one bit per conversion clock, most significant bit first. It presents each trial code to an external DAC and reads back a single comparator bit.

When the last bit is resolved, the code is copied into an output latch and an active-low interrupt is raised. The host reads the result with chip select and read strobe both low. That access drives the latched code onto the data pins through a separate output-enable and clears the interrupt. All three bus strobes are asynchronous to the conversion clock, and each passes through a synchroniser before any edge is detected.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, `intN` is 1, `dataOe` is 0, `dataOut` is 0 and `trialCode` is 0.
- R2: Holding `csN` and `wrN` low together clears `intN` to 1. Holding `wrN` low while `csN` is high leaves `intN` unchanged.
- R3: Conversion timing. On the 12th rising clock edge after `wrN` and `csN` are released, `intN` goes to 0. That count is two synchroniser stages, one start cycle, eight decision cycles and one latch-load cycle.
- R4: The first trial code after the start is 0x80. Each decided bit stays 1 when `cmpHigh` is 1 and is cleared otherwise, and the next lower bit is then set to 1.
- R5: With a comparator that reports 1 when the differential input is at or above the trial code, the result equals the differential input clamped to 0..255. If the negative input is at or above the positive input, the result is 0x00.
- R6: While `csN` and `rdN` are both low (after synchronisation), `dataOe` is 1 and `dataOut` carries the latched result. Otherwise `dataOe` is 0 and `dataOut` is 0.
- R7: A read access (`csN` and `rdN` low) returns `intN` to 1. A result that is never read keeps `intN` at 0.
- R8: A new write cycle that arrives during a conversion aborts it. The sequencer restarts from the MSB when the new write cycle ends, and its result reflects the inputs of the restarted conversion.
- R9: Holding `rdN` low while `csN` is high leaves `dataOe` at 0 and `intN` unchanged.
- R10: During a conversion, the output latch keeps the previous result. A read taken mid-conversion returns the old code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select, asynchronous |
| wrN | input | 1 | Active-low write strobe, asynchronous |
| rdN | input | 1 | Active-low read strobe, asynchronous |
| cmpHigh | input | 1 | Comparator: 1 when the analog input is at or above the trial level |
| trialCode | output | 8 | Trial code driven to the DAC |
| intN | output | 1 | Active-low conversion-done interrupt |
| dataOut | output | 8 | Latched result, zero when not enabled |
| dataOe | output | 1 | Enable for the tri-state data pad drivers |

## Verification
The hardest case to reach from the pins is a write cycle that lands in the middle of a running conversion. The abort must discard the partial code, leave the old latched result intact and restart cleanly from the MSB. The bench starts a conversion, waits a few clocks, then opens a second write cycle before the first conversion can finish. It checks both the restarted timing and the new code. It also reads in the middle of a conversion to show that the old result is still held. Random differential inputs, including negative and over-range differences, are checked against a clamp function computed in the bench.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;   // load MSB trial
    logic decide;  // resolve one bit
    logic load;    // copy code to output latch
  } sarStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CONV  = 2'd2,
    ST_LOAD  = 2'd3
  } sarState_t;

endpackage

// File: rtl/sar_bus_sync.sv
module sar_bus_sync #(
  parameter int STAGES = 2  // must be at least 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic wrN,
  input  logic rdN,
  output logic wrBegin,
  output logic wrEnd,
  output logic rdBegin,
  output logic rdSel
);

  localparam int NSIG = 3;
  localparam int CS_B = 2;
  localparam int WR_B = 1;
  localparam int RD_B = 0;

  logic [STAGES-1:0][NSIG-1:0] chain;
  logic [NSIG-1:0] synced;
  logic wrSel;
  logic wrSelQ;
  logic rdSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '1;
    end else begin
      chain <= {chain[STAGES-2:0], {csN, wrN, rdN}};
    end
  end

  assign synced = chain[STAGES-1];
  assign wrSel  = ~synced[CS_B] & ~synced[WR_B];
  assign rdSel  = ~synced[CS_B] & ~synced[RD_B];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSelQ <= 1'b0;
      rdSelQ <= 1'b0;
    end else begin
      wrSelQ <= wrSel;
      rdSelQ <= rdSel;
    end
  end

  assign wrBegin = wrSel & ~wrSelQ;
  assign wrEnd   = ~wrSel & wrSelQ;
  assign rdBegin = rdSel & ~rdSelQ;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrBegin,
  input  logic     wrEnd,
  input  logic     rdBegin,
  output sarStrb_t strb,
  output logic     intN
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  sarState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic busFree;

  assign busFree = ~wrBegin & ~wrEnd;

  always_comb begin
    strb.start  = wrEnd;
    strb.decide = busFree && (state == ST_CONV);
    strb.load   = busFree && (state == ST_LOAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (wrBegin) begin
      state  <= ST_ARMED;
      bitCnt <= '0;
    end else if (wrEnd) begin
      state  <= ST_CONV;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_CONV: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= ST_LOAD;
        end
        ST_LOAD: state <= ST_IDLE;
        default: state <= state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intN <= 1'b1;
    end else if (wrBegin) begin
      intN <= 1'b1;
    end else if (strb.load) begin
      intN <= 1'b0;
    end else if (rdBegin) begin
      intN <= 1'b1;
    end
  end

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrb_t          strb,
  input  logic              cmpHigh,
  input  logic              dataOe,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] dataOut
);

  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sarReg;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] sarNext;
  logic [DATA_W-1:0] resultLatch;

  // Per-bit next value: the bit under test takes the comparator,
  // the bit just below it becomes the new trial bit, others hold.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == DATA_W - 1) begin : g_top
      assign sarNext[i] = bitMask[i] ? cmpHigh : sarReg[i];
    end else begin : g_low
      assign sarNext[i] = bitMask[i]   ? cmpHigh :
                          bitMask[i+1] ? 1'b1    : sarReg[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg  <= '0;
      bitMask <= '0;
    end else if (strb.start) begin
      sarReg  <= MSB_ONLY;
      bitMask <= MSB_ONLY;
    end else if (strb.decide) begin
      sarReg  <= sarNext;
      bitMask <= bitMask >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultLatch <= '0;
    end else if (strb.load) begin
      resultLatch <= sarReg;
    end
  end

  assign trialCode = sarReg;
  assign dataOut   = dataOe ? resultLatch : '0;

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              cmpHigh,
  output logic [DATA_W-1:0] trialCode,
  output logic              intN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic     wrBegin;
  logic     wrEnd;
  logic     rdBegin;
  logic     rdSel;
  sarStrb_t strb;

  sar_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .wrBegin(wrBegin), .wrEnd(wrEnd), .rdBegin(rdBegin), .rdSel(rdSel)
  );

  sar_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrBegin(wrBegin), .wrEnd(wrEnd),
    .rdBegin(rdBegin), .strb(strb), .intN(intN)
  );

  assign dataOe = rdSel;

  sar_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .dataOe(dataOe), .trialCode(trialCode), .dataOut(dataOut)
  );

endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk
  import sar_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              intN,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut,
  input logic [DATA_W-1:0] trialCode,
  input logic              wrBegin,
  input logic              rdBegin,
  input sarStrb_t          strb
);

  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  AST_WRITE_CLEARS_INT: assert property (@(posedge clk) disable iff (!rstN)
    wrBegin |=> intN); // R2

  AST_LOAD_RAISES_INT: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !intN); // R3

  AST_START_AT_MSB: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (trialCode == MSB_ONLY)); // R4

  AST_UNREAD_INT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && !wrBegin && !rdBegin) |=> !intN); // R7

  AST_LATCH_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe) && !$past(strb.load)) |-> $stable(dataOut)); // R10

endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .intN(intN), .dataOe(dataOe), .dataOut(dataOut),
  .trialCode(trialCode), .wrBegin(wrBegin), .rdBegin(rdBegin), .strb(strb)
);

// File: tb/sar_bus_ctrl_tb_top.sv
module sar_bus_ctrl_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       rstN, csN, wrN, rdN, cmpHigh;
  logic [7:0] trialCode, dataOut;
  logic       intN, dataOe;
  int vpos = 0;
  int vneg = 0;
  int checks = 0;
  int errors = 0;

  // Behavioural comparator: input at or above trial level
  assign cmpHigh = ((vpos - vneg) >= int'(trialCode));

  sar_bus_ctrl dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .cmpHigh(cmpHigh), .trialCode(trialCode), .intN(intN),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic int expCode(input int p, input int n);
    int d = p - n;
    if (d < 0) return 0;
    if (d > 255) return 255;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startConv(input int p, input int n);
    vpos = p;
    vneg = n;
    @(negedge clk);
    csN = 1'b0;
    wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    csN = 1'b1;
  endtask

  task automatic waitDone(output int edges);
    edges = 0;
    while (intN && edges < 60) begin
      @(posedge clk);
      #1;
      edges++;
    end
  endtask

  task automatic readRes(output logic [7:0] d, output logic oe, output logic irq);
    @(negedge clk);
    csN = 1'b0;
    rdN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    d = dataOut;
    oe = dataOe;
    irq = intN;
    csN = 1'b1;
    rdN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic convAndCheck(input int p, input int n);
    int e;
    logic [7:0] d;
    logic oe, irq;
    startConv(p, n);
    waitDone(e);
    chk(e == 12, "R3 done timing", e, 12);
    readRes(d, oe, irq);
    chk(int'(d) == expCode(p, n), "R5 result", int'(d), expCode(p, n));
    chk(oe == 1'b1, "R6 oe on read", int'(oe), 1);
    chk(irq == 1'b1, "R7 read clears int", int'(irq), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e;
    logic [7:0] d;
    logic oe, irq;
    void'($urandom(32'd8841));
    rstN = 1'b0;
    csN = 1'b1;
    wrN = 1'b1;
    rdN = 1'b1;
    repeat (5) @(negedge clk);
    chk(intN == 1'b1, "R1 intN", int'(intN), 1);
    chk(dataOe == 1'b0, "R1 dataOe", int'(dataOe), 0);
    chk(dataOut == 8'h00, "R1 dataOut", int'(dataOut), 0);
    chk(trialCode == 8'h00, "R1 trialCode", int'(trialCode), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(dataOe == 1'b0, "R6 idle oe", int'(dataOe), 0);

    // Directed corners, R5
    convAndCheck(255, 0);
    convAndCheck(0, 0);
    convAndCheck(10, 200);
    convAndCheck(128, 0);
    convAndCheck(127, 0);
    convAndCheck(300, 20);
    convAndCheck(90, 89);

    // R4: trial sequence MSB first
    startConv(200, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(trialCode == 8'h80, "R4 first trial", int'(trialCode), 128);
    @(posedge clk);
    #1;
    chk(trialCode == 8'hC0, "R4 second trial", int'(trialCode), 192);
    @(posedge clk);
    #1;
    chk(trialCode == 8'hE0, "R4 third trial", int'(trialCode), 224);
    @(posedge clk);
    #1;
    chk(trialCode == 8'hD0, "R4 fourth trial", int'(trialCode), 208);
    waitDone(e);
    chk(intN == 1'b0, "R3 done", int'(intN), 0);

    // Unread result keeps interrupt low (R7)
    repeat (20) @(negedge clk);
    chk(intN == 1'b0, "R7 unread holds", int'(intN), 0);

    // Write strobe without chip select (R2)
    wrN = 1'b0;
    repeat (5) @(negedge clk);
    wrN = 1'b1;
    repeat (3) @(negedge clk);
    chk(intN == 1'b0, "R2 no cs write ignored", int'(intN), 0);

    // Read strobe without chip select (R9)
    rdN = 1'b0;
    repeat (4) @(negedge clk);
    chk(dataOe == 1'b0, "R9 no cs read oe", int'(dataOe), 0);
    chk(dataOut == 8'h00, "R9 no cs read data", int'(dataOut), 0);
    chk(intN == 1'b0, "R9 no cs read int", int'(intN), 0);
    rdN = 1'b1;
    repeat (3) @(negedge clk);
    readRes(d, oe, irq);
    chk(d == 8'd200, "R5 after ignored strobes", int'(d), 200);

    // Write begin clears pending interrupt (R2)
    startConv(40, 0);
    waitDone(e);
    @(negedge clk);
    csN = 1'b0;
    wrN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(intN == 1'b1, "R2 write clears int", int'(intN), 1);
    wrN = 1'b1;
    csN = 1'b1;
    waitDone(e);
    chk(e == 12, "R3 after clear", e, 12);
    readRes(d, oe, irq);
    chk(d == 8'd40, "R5 after clear", int'(d), 40);

    // Abort mid-conversion (R8)
    startConv(50, 0);
    repeat (5) @(negedge clk);
    startConv(220, 10);
    waitDone(e);
    chk(e == 12, "R8 restart timing", e, 12);
    readRes(d, oe, irq);
    chk(d == 8'd210, "R8 restart result", int'(d), 210);

    // Read during conversion returns old code (R10)
    startConv(77, 0);
    repeat (2) @(negedge clk);
    csN = 1'b0;
    rdN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dataOut == 8'd210, "R10 old result held", int'(dataOut), 210);
    chk(dataOe == 1'b1, "R6 oe mid conversion", int'(dataOe), 1);
    csN = 1'b1;
    rdN = 1'b1;
    waitDone(e);
    readRes(d, oe, irq);
    chk(d == 8'd77, "R10 new result", int'(d), 77);
    chk(dataOe == 1'b0, "R6 oe after read", int'(dataOe), 0);

    // Random differential inputs
    for (int k = 0; k < 40; k++) begin
      int p, n;
      p = int'($urandom_range(300, 0));
      n = ($urandom_range(3, 0) == 0) ? int'($urandom_range(255, 0)) : int'($urandom_range(30, 0));
      convAndCheck(p, n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule